// File: doc/BRIEF.md
# Precise-Commit Reorder Buffer

This block keeps a short, ordered record of in-flight instructions so that they may finish in any order while their effects on architectural state become visible strictly in program order. At issue, the front end writes an instruction's program counter, its destination register and a flag marking it as a store into the slot at the tail of a circular buffer. The index of that slot is handed back as the instruction's tag. Functional units later return a result, an exception flag, or both, together with that tag. The buffer then writes them into the matching slot.

Each cycle the oldest slot is inspected, but only once its result has arrived. A clean result retires in one of two ways: an ordinary instruction drives a register-file write port, and a store retires silently. A faulting entry does something else. It presents its saved PC on an interrupt output and suppresses the register write. It also refuses new instructions in that cycle. At the next edge it empties the whole buffer, which discards every younger instruction together with any results they had already produced.

Top module: `rob_commit`

## Requirements
- R1: After reset the buffer is empty: `full` is 0, `alloc_tag` is 0, and `ret_valid`, `rf_we` and `irq_valid` are 0.
- R2: Each accepted allocation returns the current tail index on `alloc_tag`. Successive accepted allocations receive 0,1,...,7 and then wrap to 0.
- R3: With 8 entries in flight, `full` is 1. An `alloc_req` is then ignored: the tag does not advance and no entry is created.
- R4: A completion with `cpl_valid`=1 stores `cpl_data` and `cpl_exc` into the slot named by `cpl_tag`, in any order relative to program order. A completion naming an unoccupied slot has no effect.
- R5: Retirement happens in program order, at most one entry per cycle, and only after the oldest entry has completed. A completion becomes eligible for retirement in the cycle after the edge that accepted it. Retiring a non-store entry without an exception gives `ret_valid`=1 and `rf_we`=1, with that entry's destination on `rf_addr` and its result on `rf_data`.
- R6: A store entry (allocated with `alloc_store`=1) that retires without an exception gives `ret_valid`=1 and `rf_we`=0.
- R7: When the oldest completed entry carries an exception, `irq_valid`=1 and `irq_pc` equals that entry's PC, and `rf_we`=0 in that cycle. At the next edge all entries are discarded and the pointers return to slot 0. Younger entries never retire, even if they had completed.
- R8: An `alloc_req` in the cycle where `irq_valid` is 1 is ignored, so the tag after the flush is 0.
- R9: An allocation and a retirement in the same cycle both take effect, leaving the occupancy unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_req | input | 1 | Issue request for a new entry |
| alloc_pc | input | 32 | PC of the issuing instruction |
| alloc_rd | input | 5 | Destination register of the issuing instruction |
| alloc_store | input | 1 | Entry is a store placeholder with no register write |
| alloc_tag | output | 3 | Slot index given to the instruction (tail) |
| full | output | 1 | No free slot; issue must stall |
| cpl_valid | input | 1 | A functional unit returns a result |
| cpl_tag | input | 3 | Slot that the result belongs to |
| cpl_data | input | 32 | Result value |
| cpl_exc | input | 1 | The instruction raised an exception |
| ret_valid | output | 1 | The oldest entry retires or faults this cycle |
| rf_we | output | 1 | Register-file write enable |
| rf_addr | output | 5 | Register-file write address |
| rf_data | output | 32 | Register-file write data |
| irq_valid | output | 1 | Precise interrupt raised by the oldest entry |
| irq_pc | output | 32 | PC of the faulting instruction |

## Verification
The hardest case to reach is a fault at the head while younger instructions have already completed, because the discard only becomes visible when those completed entries fail to retire. The bench fills all eight slots and completes them in reverse order. It places the faulting entry at every position from 0 to 7, and in some runs adds a second, younger fault. It holds `alloc_req` high through the flush cycle and replays stale tags afterwards. Clean runs use eight stride orderings for completion over mixed stores and register writes. A streaming run keeps allocation and retirement in step.

// File: rtl/rob_commit.sv
module rob_commit #(
  parameter int DEPTH = 8,
  parameter int XLEN  = 32,
  parameter int RA_W  = 5,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc_req,
  input  logic [XLEN-1:0]  alloc_pc,
  input  logic [RA_W-1:0]  alloc_rd,
  input  logic             alloc_store,
  output logic [IDX_W-1:0] alloc_tag,
  output logic             full,
  input  logic             cpl_valid,
  input  logic [IDX_W-1:0] cpl_tag,
  input  logic [XLEN-1:0]  cpl_data,
  input  logic             cpl_exc,
  output logic             ret_valid,
  output logic             rf_we,
  output logic [RA_W-1:0]  rf_addr,
  output logic [XLEN-1:0]  rf_data,
  output logic             irq_valid,
  output logic [XLEN-1:0]  irq_pc
);

  logic [DEPTH-1:0] vld, done, exc, nowb;
  logic [XLEN-1:0]  pcs [DEPTH];
  logic [XLEN-1:0]  res [DEPTH];
  logic [RA_W-1:0]  rds [DEPTH];
  logic [IDX_W-1:0] head, tail;
  logic [CNT_W-1:0] cnt;
  logic             head_rdy, take, retire;

  function automatic logic [IDX_W-1:0] nxt(input logic [IDX_W-1:0] p);
    return (p == IDX_W'(DEPTH - 1)) ? '0 : p + IDX_W'(1);
  endfunction

  assign head_rdy  = vld[head] & done[head];
  assign ret_valid = head_rdy;
  assign irq_valid = head_rdy & exc[head];
  assign irq_pc    = pcs[head];
  assign rf_we     = head_rdy & ~exc[head] & ~nowb[head];
  assign rf_addr   = rds[head];
  assign rf_data   = res[head];
  assign full      = (cnt == CNT_W'(DEPTH));
  assign alloc_tag = tail;
  assign take      = alloc_req & ~full & ~irq_valid;
  assign retire    = head_rdy & ~irq_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld  <= '0;
      done <= '0;
      exc  <= '0;
      nowb <= '0;
      head <= '0;
      tail <= '0;
      cnt  <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        pcs[i] <= '0;
        res[i] <= '0;
        rds[i] <= '0;
      end
    end else if (irq_valid) begin
      vld  <= '0;
      head <= '0;
      tail <= '0;
      cnt  <= '0;
    end else begin
      if (cpl_valid && vld[cpl_tag]) begin
        done[cpl_tag] <= 1'b1;
        exc[cpl_tag]  <= cpl_exc;
        res[cpl_tag]  <= cpl_data;
      end
      if (retire) begin
        vld[head] <= 1'b0;
        head      <= nxt(head);
      end
      if (take) begin
        vld[tail]  <= 1'b1;
        done[tail] <= 1'b0;
        exc[tail]  <= 1'b0;
        nowb[tail] <= alloc_store;
        pcs[tail]  <= alloc_pc;
        rds[tail]  <= alloc_rd;
        tail       <= nxt(tail);
      end
      cnt <= cnt + CNT_W'(take) - CNT_W'(retire);
    end
  end

  // R3
  occupancy_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(DEPTH));

  // R3
  full_holds_tail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !ret_valid) |=> $stable(tail));

  // R4
  cpl_marks_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpl_valid && vld[cpl_tag] && !irq_valid) |=> done[$past(cpl_tag)]);

  // R7
  flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |=> (cnt == '0 && !ret_valid && head == '0));

  // R9
  steady_occupancy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && retire) |=> (cnt == $past(cnt)));

endmodule

// File: tb/tb_rob_commit.sv
`timescale 1ns/1ps
module tb_rob_commit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        alloc_req = 1'b0;
  logic [31:0] alloc_pc = '0;
  logic [4:0]  alloc_rd = '0;
  logic        alloc_store = 1'b0;
  logic [2:0]  alloc_tag;
  logic        full;
  logic        cpl_valid = 1'b0;
  logic [2:0]  cpl_tag = '0;
  logic [31:0] cpl_data = '0;
  logic        cpl_exc = 1'b0;
  logic        ret_valid, rf_we, irq_valid;
  logic [4:0]  rf_addr;
  logic [31:0] rf_data, irq_pc;

  rob_commit dut (.*);

  always #2 clk = ~clk;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // independent scoreboard
  logic [31:0] m_pc [8];
  logic [31:0] m_dat [8];
  logic [4:0]  m_rd [8];
  bit          m_st [8], m_exc [8], m_done [8], m_val [8];
  int          m_head = 0, m_tail = 0, m_cnt = 0;
  bit          prev_irq = 0;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
    if (!rst_n) begin
      for (int i = 0; i < 8; i++) m_val[i] = 0;
      m_head = 0; m_tail = 0; m_cnt = 0; prev_irq = 0;
    end else begin
      bit e_ret, e_irq, e_we, can_alloc;
      e_ret = m_val[m_head] && m_done[m_head];
      e_irq = e_ret && m_exc[m_head];
      e_we  = e_ret && !m_exc[m_head] && !m_st[m_head];
      chk(ret_valid == e_ret, "R5 ret_valid", {31'b0, ret_valid}, {31'b0, e_ret});
      chk(irq_valid == e_irq, "R7 irq_valid", {31'b0, irq_valid}, {31'b0, e_irq});
      chk(rf_we == e_we, "R5 R6 R7 rf_we", {31'b0, rf_we}, {31'b0, e_we});
      if (e_we) begin
        chk(rf_addr == m_rd[m_head], "R5 rf_addr", {27'b0, rf_addr}, {27'b0, m_rd[m_head]});
        chk(rf_data == m_dat[m_head], "R4 R5 rf_data", rf_data, m_dat[m_head]);
      end
      if (e_irq) chk(irq_pc == m_pc[m_head], "R7 irq_pc", irq_pc, m_pc[m_head]);
      chk(full == (m_cnt == 8), "R3 full", {31'b0, full}, {31'b0, m_cnt == 8});
      chk(alloc_tag == 3'(m_tail), prev_irq ? "R8 tag after flush" : "R2 alloc_tag",
          {29'b0, alloc_tag}, m_tail);
      prev_irq = e_irq;
      if (e_irq) begin
        for (int i = 0; i < 8; i++) m_val[i] = 0;
        m_head = 0; m_tail = 0; m_cnt = 0;
      end else begin
        can_alloc = alloc_req && (m_cnt < 8);
        if (cpl_valid && m_val[cpl_tag]) begin
          m_done[cpl_tag] = 1; m_exc[cpl_tag] = cpl_exc; m_dat[cpl_tag] = cpl_data;
        end
        if (e_ret) begin
          m_val[m_head] = 0; m_head = (m_head + 1) % 8; m_cnt--;
        end
        if (can_alloc) begin
          m_val[m_tail] = 1; m_done[m_tail] = 0; m_exc[m_tail] = 0;
          m_st[m_tail] = alloc_store; m_pc[m_tail] = alloc_pc; m_rd[m_tail] = alloc_rd;
          m_tail = (m_tail + 1) % 8; m_cnt++;
        end
      end
    end
  end

  task automatic drive(input bit ar, input logic [31:0] pc, input logic [4:0] rd, input bit st,
                       input bit cv, input logic [2:0] ct, input logic [31:0] cd, input bit ce);
    @(negedge clk);
    alloc_req = ar; alloc_pc = pc; alloc_rd = rd; alloc_store = st;
    cpl_valid = cv; cpl_tag = ct; cpl_data = cd; cpl_exc = ce;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    idle(2);
    rst_n = 1'b1;
  endtask

  initial begin
    do_reset();
    #1;
    // R1
    chk(full == 0, "R1 full", {31'b0, full}, 0);
    chk(alloc_tag == 0, "R1 alloc_tag", {29'b0, alloc_tag}, 0);
    chk(!ret_valid && !rf_we && !irq_valid, "R1 outputs idle",
        {29'b0, ret_valid, rf_we, irq_valid}, 0);

    // R2 R3 R4 R5 R6: clean runs, stride completion orders
    for (int p = 0; p < 8; p++) begin
      int k, off;
      k = 2 * (p % 4) + 1;
      off = (p / 4) * 3;
      for (int i = 0; i < 8; i++)
        drive(1, 32'h100 * p + 4 * i, 5'(i + 1), ((i + p) % 3) == 0, 0, 0, 0, 0);
      drive(1, 32'hBAD0, 5'd31, 0, 0, 0, 0, 0);
      drive(1, 32'hBAD4, 5'd30, 0, 0, 0, 0, 0);
      #1;
      // R3
      chk(full == 1 && alloc_tag == 0, "R3 full stall", {28'b0, full, alloc_tag}, 32'h8);
      for (int i = 0; i < 8; i++) begin
        int t;
        t = (i * k + off) % 8;
        drive(0, 0, 0, 0, 1, 3'(t), 32'h1000 * p + 17 * t + 5, 0);
        if (i % 3 == 1) idle(1);
      end
      idle(10);
    end

    // R7 R8: a fault at every slot, younger results already present
    for (int e = 0; e < 8; e++) begin
      do_reset();
      for (int i = 0; i < 8; i++)
        drive(1, 32'h4000 + 4 * i + 32'h100 * e, 5'(i + 2), i == 5, 0, 0, 0, 0);
      for (int i = 7; i >= 0; i--)
        drive(0, 0, 0, 0, 1, 3'(i), 32'hA000 + i, (i == e) || (e < 4 && i == e + 3));
      for (int i = 0; i < 10; i++) drive(1, 32'hDEAD0 + 4 * i, 5'd9, 0, 0, 0, 0, 0);
      for (int i = 0; i < 8; i++) drive(0, 0, 0, 0, 1, 3'(i), 32'h5EE0 + i, 0);
      idle(10);
    end

    // R9: allocation and retirement in the same cycle
    do_reset();
    begin
      logic [2:0] last;
      drive(1, 32'h8000, 5'd3, 0, 0, 0, 0, 0);
      #1 last = alloc_tag;
      drive(1, 32'h8004, 5'd4, 0, 0, 0, 0, 0);
      for (int i = 0; i < 40; i++) begin
        logic [2:0] cur;
        #1 cur = alloc_tag;
        drive(1, 32'h8008 + 4 * i, 5'(5 + i % 20), i % 4 == 3, 1, last - 3'd1, 32'hC000 + i, 0);
        last = cur;
      end
      #1;
      // R9
      chk(full == 0, "R9 occupancy steady", {31'b0, full}, 0);
      idle(12);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule